// File: doc/BRIEF.md
# Cross-Thread Software Interrupt Vector Receiver

This block delivers software interrupts between hardware threads. Any agent posts a dispatch word that names a destination thread and one of 64 vector numbers. The block sets the matching bit in that thread's 64-bit pending set and raises the thread's interrupt request line. The request stays up until every pending bit of that thread is gone.

The receiving thread works through a synchronous read port. A status read returns the whole pending set and changes nothing. A take read returns the number of the highest pending vector and clears that bit in the same cycle. This lets a handler take vectors one at a time in descending order, with no separate acknowledge step. Read data is registered and appears one cycle after the request. It holds its value until the next read.

Top module: `intvec_rx`

## Requirements
- R1: After synchronous active-high reset, every pending set is zero, every bit of `irq` is low and `rd_data` is zero.
- R2: A dispatch (`disp_we` high) takes the vector number from `disp_data[5:0]` and the destination thread from `disp_data[13:8]`. It ignores all other bits of `disp_data`. A destination thread number at or above `NUM_THREADS` changes no state.
- R3: A status read (`rd_en` high, `rd_sel` = 0) returns the 64-bit pending set of thread `rd_tid` on `rd_data` after the next clock edge. Bit N is set when vector N is pending, so a lone vector N reads as 1 << N. The read clears nothing.
- R4: A take read (`rd_en` high, `rd_sel` = 1) returns the highest-numbered pending vector of thread `rd_tid` in `rd_data[5:0]`, with `rd_data[63:6]` zero, after the next clock edge. The same edge clears only that vector's pending bit.
- R5: A take read on a thread with nothing pending returns 0 and changes no state.
- R6: `irq[t]` is high exactly while thread t has at least one pending bit.
- R7: In a cycle where a dispatch sets vector N of thread t and a take read clears vector N of thread t, the set wins and vector N stays pending. The read still returns N.
- R8: Every vector 0 to 63 of every thread can be delivered in turn. Each delivery raises the request, and a take read then drops it.
- R9: A dispatch to one thread leaves the pending sets of all other threads unchanged.
- R10: Dispatching a vector that is already pending leaves a single pending bit for it, so one take read clears it.
- R11: A read with `rd_tid` at or above `NUM_THREADS` returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_we | input | 1 | Dispatch strobe |
| disp_data | input | 64 | Dispatch word: vector in bits 5:0, destination thread in bits 13:8 |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0 = status read, 1 = take read (clears the returned vector) |
| rd_tid | input | 6 | Thread whose registers are read |
| rd_data | output | 64 | Registered read data, valid one cycle after `rd_en` |
| irq | output | NUM_THREADS | Per-thread interrupt request |

## Verification
The hardest case to reach from the ports is a dispatch and a take read that land on the same vector of the same thread in one clock. The bench pre-loads that vector, then raises `disp_we` and `rd_en` together on one falling edge. A status read follows to show the bit survived. A companion case targets a different vector in the same cycle, which shows that the read returns the old winner while the new bit lands. Drain order with several vectors pending is checked by loading a scattered set and taking until empty, against an arithmetic model.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

    localparam int DATA_W   = 64;
    localparam int VEC_W    = 6;
    localparam int NUM_VECS = 1 << VEC_W;
    localparam int TID_W    = 6;
    localparam int TID_LSB  = 8;

    typedef enum logic {
        RD_STATUS = 1'b0,
        RD_TAKE   = 1'b1
    } rd_kind_e;

    typedef struct packed {
        logic             valid;
        logic [TID_W-1:0] tid;
        logic [VEC_W-1:0] vec;
    } dispatch_t;

    typedef struct packed {
        logic             found;
        logic [VEC_W-1:0] vec;
    } vec_pick_t;

    function automatic dispatch_t unpack_dispatch(input logic we,
                                                  input logic [DATA_W-1:0] d);
        dispatch_t r;
        r.valid = we;
        r.tid   = d[TID_LSB +: TID_W];
        r.vec   = d[VEC_W-1:0];
        return r;
    endfunction

    function automatic logic [NUM_VECS-1:0] vec_onehot(input logic [VEC_W-1:0] v);
        logic [NUM_VECS-1:0] m;
        m = '0;
        m[v] = 1'b1;
        return m;
    endfunction

    function automatic vec_pick_t pick_highest(input logic [NUM_VECS-1:0] p);
        vec_pick_t r;
        r = '0;
        for (int i = 0; i < NUM_VECS; i++) begin
            if (p[i]) begin
                r.found = 1'b1;
                r.vec   = VEC_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/intvec_decode.sv
module intvec_decode
    import intvec_pkg::*;
#(
    parameter int NUM_THREADS = 8
) (
    input  logic                                   disp_we,
    input  logic [DATA_W-1:0]                      disp_data,
    output logic [NUM_THREADS-1:0][NUM_VECS-1:0]   set_mask
);
    dispatch_t d;
    logic [NUM_VECS-1:0] vec_bit;
    logic unused_disp_bits;

    assign d                = unpack_dispatch(disp_we, disp_data);
    assign vec_bit          = vec_onehot(d.vec);
    assign unused_disp_bits = ^{disp_data[DATA_W-1:TID_LSB+TID_W],
                                disp_data[TID_LSB-1:VEC_W]};

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_comb begin
            if (d.valid && (32'(d.tid) == 32'(t)))
                set_mask[t] = vec_bit;
            else
                set_mask[t] = '0;
        end
    end
endmodule

// File: rtl/intvec_pend_bank.sv
module intvec_pend_bank
    import intvec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_VECS-1:0] set_bits,
    input  logic [NUM_VECS-1:0] clr_bits,
    output logic [NUM_VECS-1:0] pend,
    output logic                irq
);
    logic [NUM_VECS-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_bits) | set_bits;
    end

    assign pend = pend_q;
    assign irq  = |pend_q;
endmodule

// File: rtl/intvec_prio.sv
module intvec_prio
    import intvec_pkg::*;
(
    input  logic [NUM_VECS-1:0] pend,
    output logic                found,
    output logic [VEC_W-1:0]    vec
);
    vec_pick_t pick;

    assign pick  = pick_highest(pend);
    assign found = pick.found;
    assign vec   = pick.vec;
endmodule

// File: rtl/intvec_rx.sv
module intvec_rx
    import intvec_pkg::*;
#(
    parameter int NUM_THREADS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   disp_we,
    input  logic [63:0]            disp_data,
    input  logic                   rd_en,
    input  logic                   rd_sel,
    input  logic [5:0]             rd_tid,
    output logic [63:0]            rd_data,
    output logic [NUM_THREADS-1:0] irq
);
    localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic [NUM_THREADS-1:0][NUM_VECS-1:0] set_mask;
    logic [NUM_THREADS-1:0][NUM_VECS-1:0] clr_mask;
    logic [NUM_THREADS-1:0][NUM_VECS-1:0] pend;

    logic                rd_ok;
    logic [THR_W-1:0]    rd_idx;
    logic [NUM_VECS-1:0] sel_pend;
    logic                pick_found;
    logic [VEC_W-1:0]    pick_vec;
    logic                take_fire;
    rd_kind_e            rd_kind;

    intvec_decode #(.NUM_THREADS(NUM_THREADS)) u_dec (
        .disp_we   (disp_we),
        .disp_data (disp_data),
        .set_mask  (set_mask)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bank
        intvec_pend_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_bits (set_mask[t]),
            .clr_bits (clr_mask[t]),
            .pend     (pend[t]),
            .irq      (irq[t])
        );
    end

    assign rd_kind  = rd_kind_e'(rd_sel);
    assign rd_ok    = 32'(rd_tid) < 32'(NUM_THREADS);
    assign rd_idx   = rd_tid[THR_W-1:0];
    assign sel_pend = rd_ok ? pend[rd_idx] : '0;

    intvec_prio u_prio (
        .pend  (sel_pend),
        .found (pick_found),
        .vec   (pick_vec)
    );

    assign take_fire = rd_en && (rd_kind == RD_TAKE) && rd_ok && pick_found;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_clr
        always_comb begin
            if (take_fire && (32'(rd_idx) == 32'(t)))
                clr_mask[t] = vec_onehot(pick_vec);
            else
                clr_mask[t] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_kind == RD_TAKE)
                rd_data <= {{(DATA_W-VEC_W){1'b0}}, pick_vec};
            else
                rd_data <= sel_pend;
        end
    end
endmodule

// File: rtl/intvec_rx_chk.sv
module intvec_rx_chk
    import intvec_pkg::*;
#(
    parameter int NUM_THREADS = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   disp_we,
    input logic [63:0]            disp_data,
    input logic                   rd_en,
    input logic                   rd_sel,
    input logic [5:0]             rd_tid,
    input logic [63:0]            rd_data,
    input logic [NUM_THREADS-1:0] irq
);
    localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic             d_ok;
    logic [THR_W-1:0] d_idx;
    logic             r_ok;
    logic [THR_W-1:0] r_idx;
    logic             unused_chk;

    assign d_ok  = 32'(disp_data[TID_LSB +: TID_W]) < 32'(NUM_THREADS);
    assign d_idx = disp_data[TID_LSB +: THR_W];
    assign r_ok  = 32'(rd_tid) < 32'(NUM_THREADS);
    assign r_idx = rd_tid[THR_W-1:0];
    assign unused_chk = ^{disp_data[63:TID_LSB+TID_W], disp_data[TID_LSB-1:0]};

    // R1: state is clear right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0) && (rd_data == '0));

    // R2 / R6: a valid dispatch raises the destination request
    a_r2_dispatch_raises: assert property (@(posedge clk) disable iff (rst)
        disp_we && d_ok |=> irq[$past(d_idx)]);

    // R3: request lines change only through dispatch or take reads
    a_r3_status_no_effect: assert property (@(posedge clk) disable iff (rst)
        !disp_we && !(rd_en && rd_sel) |=> $stable(irq));

    // R6: status data is non-zero exactly when the request was up
    a_r6_status_matches_irq: assert property (@(posedge clk) disable iff (rst)
        rd_en && !rd_sel && r_ok |=> ((rd_data != '0) == $past(irq[r_idx])));

    // R4: take data carries only a vector number
    a_r4_take_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_sel |=> rd_data[63:VEC_W] == '0);

    // R5: take on an idle thread returns zero
    a_r5_idle_take_zero: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_sel && r_ok && !irq[r_idx] |=> rd_data == '0);

    // R11: out-of-range thread reads return zero
    a_r11_bad_tid_zero: assert property (@(posedge clk) disable iff (rst)
        rd_en && !r_ok |=> rd_data == '0);
endmodule

bind intvec_rx intvec_rx_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (.*);

// File: tb/intvec_rx_tb.sv
module intvec_rx_tb;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          disp_we;
    logic [63:0]   disp_data;
    logic          rd_en;
    logic          rd_sel;
    logic [5:0]    rd_tid;
    logic [63:0]   rd_data;
    logic [NT-1:0] irq;

    int n_run  = 0;
    int n_fail = 0;
    logic [63:0] model [NT];

    always #5 clk = ~clk;

    intvec_rx #(.NUM_THREADS(NT)) u_dut (
        .clk(clk), .rst(rst), .disp_we(disp_we), .disp_data(disp_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_tid(rd_tid),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] word(input int tid, input int vec, input logic [63:0] junk);
        logic [63:0] w;
        w = junk & ~64'h3F3F;
        w[13:8] = 6'(tid);
        w[5:0]  = 6'(vec);
        return w;
    endfunction

    function automatic logic [NT-1:0] exp_irq();
        logic [NT-1:0] r;
        for (int t = 0; t < NT; t++) r[t] = (model[t] != 0);
        return r;
    endfunction

    function automatic int highest(input logic [63:0] p);
        int h = 0;
        for (int i = 0; i < 64; i++) if (p[i]) h = i;
        return h;
    endfunction

    task automatic dispatch(input int tid, input int vec, input logic [63:0] junk);
        disp_we = 1'b1;
        disp_data = word(tid, vec, junk);
        @(negedge clk);
        disp_we = 1'b0;
        if (tid < NT) model[tid][vec] = 1'b1;
    endtask

    task automatic rd(input int tid, input logic sel, output logic [63:0] d);
        rd_en = 1'b1; rd_sel = sel; rd_tid = 6'(tid);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic take_check(input string req, input int tid);
        logic [63:0] d;
        int e;
        e = (tid < NT) ? highest(model[tid]) : 0;
        rd(tid, 1'b1, d);
        check(req, d, 64'(e));
        if (tid < NT && model[tid] != 0) model[tid][e] = 1'b0;
    endtask

    task automatic status_check(input string req, input int tid);
        logic [63:0] d;
        rd(tid, 1'b0, d);
        check(req, d, (tid < NT) ? model[tid] : 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        rst = 1'b1; disp_we = 0; disp_data = 0; rd_en = 0; rd_sel = 0; rd_tid = 0;
        for (int t = 0; t < NT; t++) model[t] = '0;
        repeat (3) @(negedge clk);
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 rd_data", rd_data, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        for (int t = 0; t < NT; t++) status_check("R1 status", t);

        // R8 R2 R9 R3 R4 R6: full sweep, junk in ignored bits
        for (int t = 0; t < NT; t++) begin
            for (int v = 0; v < 64; v++) begin
                dispatch(t, v, {32'hA5C3_F00F, 26'h2AB_CDEF, 6'(v)} << 6);
                check("R6 irq raised", 64'(irq), 64'(exp_irq()));
                status_check("R3 status one-hot", t);
                check("R3 value 1<<N", model[t], 64'h1 << v);
                take_check("R4 take returns N", t);
                check("R8 irq dropped", 64'(irq), 64'h0);
                status_check("R3 status cleared", t);
                take_check("R5 idle take", t);
            end
        end

        // R4: several pending, drained highest first
        dispatch(2, 3, 0); dispatch(2, 40, 0); dispatch(2, 17, 0); dispatch(2, 63, 0);
        dispatch(6, 0, 0);
        for (int k = 0; k < 5; k++) begin
            take_check("R4 drain order", 2);
            status_check("R4 only one cleared", 2);
            check("R9 other thread", 64'(irq), 64'(exp_irq()));
        end
        take_check("R4 vector 0", 6);
        check("R6 all low", 64'(irq), 64'h0);

        // R2 R11: out-of-range thread numbers
        dispatch(NT, 5, 0);
        dispatch(63, 9, 64'hFFFF_FFFF_FFFF_0000);
        check("R2 bad tid ignored", 64'(irq), 64'h0);
        rd(NT + 1, 1'b0, d);
        check("R11 bad tid status", d, 64'h0);
        rd(40, 1'b1, d);
        check("R11 bad tid take", d, 64'h0);

        // R10: repeated dispatch
        dispatch(1, 7, 0); dispatch(1, 7, 0);
        status_check("R10 single bit", 1);
        take_check("R10 take", 1);
        check("R10 irq low", 64'(irq), 64'h0);

        // R7: set and clear of same vector together
        dispatch(5, 20, 0);
        disp_we = 1'b1; disp_data = word(5, 20, 0);
        rd_en = 1'b1; rd_sel = 1'b1; rd_tid = 6'd5;
        @(negedge clk);
        disp_we = 1'b0; rd_en = 1'b0;
        check("R7 read value", rd_data, 64'd20);
        check("R7 irq held", 64'(irq), 64'h20);
        status_check("R7 set wins", 5);
        take_check("R7 final take", 5);

        // R7: different vector set while take clears the old one
        dispatch(5, 10, 0);
        disp_we = 1'b1; disp_data = word(5, 30, 0);
        rd_en = 1'b1; rd_sel = 1'b1; rd_tid = 6'd5;
        @(negedge clk);
        disp_we = 1'b0; rd_en = 1'b0;
        model[5] = 64'h1 << 30;
        check("R7 old winner", rd_data, 64'd10);
        status_check("R7 new bit", 5);
        take_check("R7 drain", 5);
        status_check("R3 empty", 5);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule